// File: doc/BRIEF.md
# Zero-to-Sixty Hold Counter

A two-digit seconds counter that runs from 00 up to 60 and then freezes. A one-cycle tick enable, normally produced once per second elsewhere on the chip, advances a decimal units digit. A three-bit tens digit steps up each time the units digit rolls over from 9. When the display reaches 60, further ticks are ignored and a `held` flag stays high.

The only way to leave 60 is a push button. The raw button signal first passes through a synchronizer and then a stability filter. After that it clears both digits to 00, and counting resumes once the button is released. Each digit is also decoded to an active-high seven-segment pattern for a common-cathode display.

Everything runs on the rising edge of one clock. A chip-level asynchronous reset sets the initial state.

Top module: `sixty_hold_counter`

## Requirements
- R1: After the asynchronous reset is released, both digits read 0, `held_o` is low and both segment outputs show the pattern for 0.
- R2: Each cycle with `tick_i` high advances the units digit by one, provided the counter is not held and no clear is active. A cycle with `tick_i` low leaves both digits unchanged.
- R3: A tick while the units digit is 9 sets the units digit to 0 and raises the tens digit by exactly one, in that same cycle.
- R4: When the tens digit is 6 and the units digit is 0, `held_o` is high and ticks change neither digit.
- R5: Once the filtered button level is high, both digits are 0 on the next cycle and `held_o` falls, so counting resumes after release.
- R6: While the filtered button level is high, clearing takes priority over a tick in the same cycle.
- R7: Button bounce whose high or low stretches last fewer than STABLE_CYCLES cycles never clears the count.
- R8: Segment bit 0 drives segment a and bit 6 drives segment g, active high. Digits 0 to 9 map to hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. The tens digit is decoded after zero-extension to four bits.
- R9: A button press takes effect only after the raw level has passed the two-flop synchronizer and then stayed unchanged for STABLE_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous active-low chip reset |
| tick_i | input | 1 | One-cycle advance enable |
| btn_raw_i | input | 1 | Raw push button, high when pressed |
| units_o | output | 4 | Units digit, binary 0 to 9 |
| tens_o | output | 3 | Tens digit, binary 0 to 6 |
| held_o | output | 1 | High while frozen at 60 |
| seg_units_o | output | 7 | Segments a..g for the units digit |
| seg_tens_o | output | 7 | Segments a..g for the tens digit |

## Verification
A bad units state shows up at `units_o` and `seg_units_o` at the very next tick. A dropped or doubled carry puts the tens digit off by one at the first units rollover, so within ten ticks. A hold comparison that is wrong either lets the count go past 60 on the next tick or freezes it early. A filter that is too short or too long shows as a clear during bounce, or as a clear that arrives too early or too late around the STABLE_CYCLES boundary. All of these are visible at the ports within a few tens of cycles of the stimulus.

// File: rtl/sixty_hold_pkg.sv
package sixty_hold_pkg;
   localparam int UNITS_W   = 4;
   localparam int TENS_W    = 3;
   localparam int SEG_W     = 7;
   localparam int UNITS_TOP = 9;
   localparam int TENS_STOP = 6;
   typedef logic [UNITS_W-1:0] units_t;
   typedef logic [TENS_W-1:0]  tens_t;
   typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/sixty_btn_filter.sv
module sixty_btn_filter #(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic raw_i,
   output logic level_o
);
   localparam int CW = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STABLE_CYCLES < 1) begin : g_bad_stable
      $error("STABLE_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (STABLE_CYCLES == 1) begin : g_direct
      logic lvl_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) lvl_q <= 1'b0;
         else         lvl_q <= synced;
      end
      assign level_o = lvl_q;
   end else begin : g_filter
      logic [CW-1:0] cnt_q;
      logic          lvl_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
         end else if (synced == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(STABLE_CYCLES-1)) begin
            cnt_q <= '0;
            lvl_q <= synced;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
      assign level_o = lvl_q;

      // R9: the filtered level may only move after a full stable window
      a_r9_window_done: assert property (@(posedge clk) disable iff (!arst_n)
         !$stable(lvl_q) |-> $past(cnt_q) == CW'(STABLE_CYCLES-1));
   end
endmodule

// File: rtl/sixty_count_core.sv
module sixty_count_core
   import sixty_hold_pkg::*;
(
   input  logic   clk,
   input  logic   arst_n,
   input  logic   tick_i,
   input  logic   clr_i,
   output units_t units_o,
   output tens_t  tens_o,
   output logic   held_o
);
   units_t units_q;
   tens_t  tens_q;
   logic   at_stop;
   logic   advance;
   logic   wrap;

   assign at_stop = (tens_q == tens_t'(TENS_STOP));
   assign advance = tick_i && !at_stop;
   assign wrap    = (units_q == units_t'(UNITS_TOP));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         units_q <= '0;
         tens_q  <= '0;
      end else if (clr_i) begin
         units_q <= '0;
         tens_q  <= '0;
      end else if (advance) begin
         if (wrap) begin
            units_q <= '0;
            tens_q  <= tens_q + 1'b1;
         end else begin
            units_q <= units_q + 1'b1;
         end
      end
   end

   assign units_o = units_q;
   assign tens_o  = tens_q;
   assign held_o  = at_stop;

   a_r2_units_range: assert property (@(posedge clk) disable iff (!arst_n)
      units_q <= units_t'(UNITS_TOP));
   a_r4_tens_ceiling: assert property (@(posedge clk) disable iff (!arst_n)
      tens_q <= tens_t'(TENS_STOP));
   a_r4_frozen: assert property (@(posedge clk) disable iff (!arst_n)
      (held_o && !clr_i) |=> ($stable(units_q) && $stable(tens_q)));
   a_r3_carry: assert property (@(posedge clk) disable iff (!arst_n)
      (tick_i && !held_o && !clr_i && units_q == units_t'(UNITS_TOP))
      |=> (units_q == '0 && tens_q == $past(tens_q) + tens_t'(1)));
   a_r6_clear_wins: assert property (@(posedge clk) disable iff (!arst_n)
      clr_i |=> (units_q == '0 && tens_q == '0 && !held_o));
   a_r2_idle: assert property (@(posedge clk) disable iff (!arst_n)
      (!tick_i && !clr_i) |=> ($stable(units_q) && $stable(tens_q)));
endmodule

// File: rtl/sixty_seg_decode.sv
module sixty_seg_decode
   import sixty_hold_pkg::*;
(
   input  logic [UNITS_W-1:0] code_i,
   output seg_t               seg_o
);
   always_comb begin
      case (code_i)
         4'd0:    seg_o = 7'h3F;
         4'd1:    seg_o = 7'h06;
         4'd2:    seg_o = 7'h5B;
         4'd3:    seg_o = 7'h4F;
         4'd4:    seg_o = 7'h66;
         4'd5:    seg_o = 7'h6D;
         4'd6:    seg_o = 7'h7D;
         4'd7:    seg_o = 7'h07;
         4'd8:    seg_o = 7'h7F;
         4'd9:    seg_o = 7'h6F;
         default: seg_o = 7'h00;
      endcase
   end
endmodule

// File: rtl/sixty_hold_counter.sv
module sixty_hold_counter
   import sixty_hold_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       tick_i,
   input  logic       btn_raw_i,
   output logic [3:0] units_o,
   output logic [2:0] tens_o,
   output logic       held_o,
   output logic [6:0] seg_units_o,
   output logic [6:0] seg_tens_o
);
   logic   clr;
   units_t units;
   tens_t  tens;
   logic [UNITS_W-1:0] codes [2];
   seg_t               segs  [2];

   sixty_btn_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
   ) u_filter (
      .clk    (clk),
      .arst_n (arst_n),
      .raw_i  (btn_raw_i),
      .level_o(clr)
   );

   sixty_count_core u_core (
      .clk    (clk),
      .arst_n (arst_n),
      .tick_i (tick_i),
      .clr_i  (clr),
      .units_o(units),
      .tens_o (tens),
      .held_o (held_o)
   );

   assign codes[0] = units;
   assign codes[1] = {{(UNITS_W-TENS_W){1'b0}}, tens};

   for (genvar d = 0; d < 2; d++) begin : g_digit
      sixty_seg_decode u_dec (
         .code_i(codes[d]),
         .seg_o (segs[d])
      );
   end

   assign units_o     = units;
   assign tens_o      = tens;
   assign seg_units_o = segs[0];
   assign seg_tens_o  = segs[1];

   // R8: a valid digit always lights at least two segments
   a_r8_lit: assert property (@(posedge clk) disable iff (!arst_n)
      $countones(seg_units_o) >= 2 && $countones(seg_tens_o) >= 2);
   // R5: leaving the clear state always starts from 00
   a_r5_release_zero: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(clr) |-> (units_o == 4'd0 && tens_o == 3'd0));
endmodule

// File: tb/sixty_hold_counter_tb.sv
`timescale 1ns/1ps
module sixty_hold_counter_tb;
   localparam int STABLE = 16;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       btn_raw_i = 1'b0;
   logic [3:0] units_o;
   logic [2:0] tens_o;
   logic       held_o;
   logic [6:0] seg_units_o, seg_tens_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sixty_hold_counter #(.SYNC_STAGES(2), .STABLE_CYCLES(STABLE)) u_dut (
      .clk(clk), .arst_n(arst_n), .tick_i(tick_i), .btn_raw_i(btn_raw_i),
      .units_o(units_o), .tens_o(tens_o), .held_o(held_o),
      .seg_units_o(seg_units_o), .seg_tens_o(seg_tens_o)
   );

   function automatic logic [6:0] seg_of(input int v);
      case (v)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
      endcase
   endfunction

   task automatic check_val(input string req, input int n);
      int eu, et;
      logic eh;
      eu = n % 10;
      et = n / 10;
      eh = (n == 60);
      tests++;
      if (units_o !== 4'(eu) || tens_o !== 3'(et) || held_o !== eh ||
          seg_units_o !== seg_of(eu) || seg_tens_o !== seg_of(et)) begin
         fails++;
         $display("FAIL %s: got %0d%0d held=%0b seg=%h/%h, expected %0d%0d held=%0b seg=%h/%h",
                  req, tens_o, units_o, held_o, seg_tens_o, seg_units_o,
                  et, eu, eh, seg_of(et), seg_of(eu));
      end
   endtask

   task automatic tick_once();
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int exp_n;
      idle(3);
      arst_n = 1'b1;
      idle(2);
      check_val("R1", 0);
      check_val("R8", 0);

      // R2/R3/R8: sweep 00..60 with idle gaps
      exp_n = 0;
      for (int k = 1; k <= 60; k++) begin
         tick_once();
         exp_n = k;
         check_val((k % 10 == 0) ? "R3" : "R2", exp_n);
         if (k % 7 == 0) begin
            idle(3);
            check_val("R2", exp_n);
         end
      end

      // R4: extra ticks must not move the count
      for (int k = 0; k < 12; k++) begin
         tick_once();
         check_val("R4", 60);
      end

      // R7: short bounce pulses never clear
      for (int b = 0; b < 6; b++) begin
         @(negedge clk) btn_raw_i = 1'b1;
         idle(STABLE / 2);
         btn_raw_i = 1'b0;
         idle(3);
      end
      idle(STABLE + 4);
      check_val("R7", 60);

      // R9: steady press, not yet accepted before sync plus window
      @(negedge clk) btn_raw_i = 1'b1;
      idle(STABLE - 4);
      check_val("R9", 60);
      idle(12);
      check_val("R5", 0);

      // R6: ticks while clearing are overridden
      for (int k = 0; k < 4; k++) begin
         tick_once();
         check_val("R6", 0);
      end

      // release with bounce, then resume
      btn_raw_i = 1'b0;
      idle(2);
      btn_raw_i = 1'b1;
      idle(2);
      btn_raw_i = 1'b0;
      idle(STABLE + 10);
      check_val("R5", 0);
      for (int k = 1; k <= 23; k++) begin
         tick_once();
         check_val("R2", k);
      end

      // R5: clear from a running (not held) count
      @(negedge clk) btn_raw_i = 1'b1;
      idle(STABLE + 6);
      check_val("R5", 0);
      btn_raw_i = 1'b0;
      idle(STABLE + 6);
      tick_once();
      check_val("R2", 1);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
      end
      #1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule